// File: doc/BRIEF.md
# Event Timer with Shared Prescaler

An 8-bit up-counter runs either on every cycle of the instruction clock or on chosen transitions of an external pin. One prescaler serves two users: this counter and a watchdog counter. A bit in the mode register hands the prescaler to one of them. The user that does not own the prescaler runs unscaled. When the prescaler serves the counter, its ratio is one power of two coarser than the same rate code gives the watchdog.

When the counter wraps from 0xFF to 0x00 it sets a sticky overflow flag, which an explicit clear strobe resets. The watchdog counts a free-running tick, either directly or through the prescaler. When it wraps, it raises a one-cycle time-out pulse. A clear strobe restarts the watchdog.

The host programs the block through a mode write port and a counter write port, and reads the counter value directly.

Top module: `tmr_prescaled_timer`

## Requirements
- R1: After reset the counter reads 0, the overflow flag and time-out are 0, and the mode register holds all ones. So the prescaler is on the watchdog with rate 7, and the counter counts falling pin transitions one for one.
- R2: Mode fields are as follows. Bits [2:0] hold the rate code. Bit 3 assigns the prescaler (0 = counter, 1 = watchdog). Bit 4 selects the pin transition (0 = rising, 1 = falling). Bit 5 selects the counter source (0 = instruction clock, 1 = pin).
- R3: With the prescaler on the counter, the counter advances once per 2^(rate+1) source events.
- R4: With source 0 the counter sees one event per clock cycle. With source 1 it sees only selected pin transitions, and the clock alone does not advance it.
- R5: A selected pin transition advances an unscaled counter on the third rising clock edge after the pin changes. The non-selected transition has no effect.
- R6: A counter increment from 0xFF to 0x00 sets the overflow flag. The flag holds until a clear strobe. If a set and a clear come in the same cycle, the set wins.
- R7: A counter write loads the value with no increment in that cycle. If the prescaler is on the counter, the write also restarts the prescaler.
- R8: A watchdog clear zeroes the watchdog counter. It also restarts the prescaler only when the prescaler is on the watchdog.
- R9: With the prescaler on the watchdog, the watchdog advances once per 2^rate ticks; otherwise it advances once per tick. The time-out is a one-cycle pulse, high in the cycle after the count wraps from 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle per instruction cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 6 | Mode register write data |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write data |
| cnt_o | output | 8 | Current counter value |
| pin_i | input | 1 | External count pin, asynchronous |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| wdt_tick_i | input | 1 | Free-running watchdog tick, one cycle wide |
| ovf_flag_o | output | 1 | Sticky counter overflow flag |
| wdt_timeout_o | output | 1 | Watchdog time-out pulse |

## Verification
A counter write shows on cnt_o after one edge. With a ratio of N, the first increment lands on the N-th edge after that write. A pin transition takes three edges to reach the counter: two synchronizer stages, then the count edge. The overflow flag and the time-out appear one edge after the increment that wraps the count.

Each task drives its inputs and samples 1 ns after a rising edge. It counts edges to the cycle before a result is due and checks that the old value is still there. It then checks the new value one edge later, so an early or a late result both fail.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       src_pin;     // 0: instruction clock, 1: pin transitions
    logic       fall_edge;   // 0: rising, 1: falling
    logic       pre_to_wdt;  // 0: prescaler on counter, 1: on watchdog
    logic [2:0] rate;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= synced;
    end
  end

  assign edge_o = fall_sel_i ? (prev_q & ~synced) : (~prev_q & synced);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8,
  localparam int LOG_W = $clog2(PRE_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [LOG_W-1:0] ratio_log_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  // terminal count = 2^ratio_log - 1
  assign lim    = ~({PRE_W{1'b1}} << ratio_log_i);
  assign tick_o = evt_i & ~clr_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (evt_i)    cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R7 R8
endmodule

// File: rtl/tmr_wdt.sv
module tmr_wdt #(
  parameter int WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic timeout_o
);
  logic [WDT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= inc_i & (cnt_q == '1);
      if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_WDT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !timeout_o)); // R8
  AST_TO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R9
endmodule

// File: rtl/tmr_prescaled_timer.sv
module tmr_prescaled_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  input  logic              pin_i,
  input  logic              flag_clr_i,
  input  logic              wdt_clr_i,
  input  logic              wdt_tick_i,
  output logic              ovf_flag_o,
  output logic              wdt_timeout_o
);
  localparam int LOG_W = $clog2(PRE_W + 1);

  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             pin_edge;
  logic             tmr_evt;
  logic             pre_evt;
  logic             pre_clr;
  logic             pre_tick;
  logic [LOG_W-1:0] ratio_log;
  logic             tmr_inc;
  logic             wdt_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '1;
    else if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);
  end

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .fall_sel_i (mode_q.fall_edge),
    .edge_o     (pin_edge)
  );

  assign tmr_evt   = mode_q.src_pin ? pin_edge : 1'b1;
  assign pre_evt   = mode_q.pre_to_wdt ? wdt_tick_i : tmr_evt;
  assign pre_clr   = mode_q.pre_to_wdt ? wdt_clr_i : cnt_we_i;
  // counter side is one power of two coarser
  assign ratio_log = mode_q.pre_to_wdt ? LOG_W'(mode_q.rate)
                                       : LOG_W'(mode_q.rate) + LOG_W'(1);

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (pre_clr),
    .evt_i       (pre_evt),
    .ratio_log_i (ratio_log),
    .tick_o      (pre_tick)
  );

  assign tmr_inc = mode_q.pre_to_wdt ? tmr_evt : pre_tick;
  assign wdt_inc = mode_q.pre_to_wdt ? pre_tick : wdt_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (tmr_inc)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  flag_q <= 1'b0;
    else if (tmr_inc && !cnt_we_i && cnt_q == '1) flag_q <= 1'b1;
    else if (flag_clr_i)                          flag_q <= 1'b0;
  end

  tmr_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (wdt_clr_i),
    .inc_i     (wdt_inc),
    .timeout_o (wdt_timeout_o)
  );

  assign cnt_o      = cnt_q;
  assign ovf_flag_o = flag_q;

  AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_inc && !cnt_we_i && cnt_q == '1) |=> (ovf_flag_o && cnt_o == '0)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && !tmr_inc) |=> $stable(cnt_o)); // R4
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i))); // R7
endmodule

// File: tb/tmr_prescaled_timer_tb_top.sv
module tmr_prescaled_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [5:0] mode_wdata_i = '0;
  logic       cnt_we_i = 1'b0;
  logic [7:0] cnt_wdata_i = '0;
  logic [7:0] cnt_o;
  logic       pin_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       wdt_clr_i = 1'b0;
  logic       wdt_tick_i = 1'b0;
  logic       ovf_flag_o;
  logic       wdt_timeout_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  tmr_prescaled_timer dut_i (
    .clk_i, .rst_ni, .mode_we_i, .mode_wdata_i, .cnt_we_i, .cnt_wdata_i,
    .cnt_o, .pin_i, .flag_clr_i, .wdt_clr_i, .wdt_tick_i, .ovf_flag_o,
    .wdt_timeout_o
  );

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [5:0] v);
    mode_we_i = 1'b1; mode_wdata_i = v; cyc(1); mode_we_i = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we_i = 1'b1; cnt_wdata_i = v; cyc(1); cnt_we_i = 1'b0;
    chk("R7 load", cnt_o, v);
  endtask

  task automatic t_reset;
    chk("R1 cnt", cnt_o, 0);
    chk("R1 flag", ovf_flag_o, 0);
    chk("R1 timeout", wdt_timeout_o, 0);
    pin_i = 1'b1; cyc(4);
    chk("R1 rising ignored", cnt_o, 0);
    pin_i = 1'b0; cyc(2);
    chk("R1 R5 not yet", cnt_o, 0);
    cyc(1);
    chk("R1 R5 falling counted", cnt_o, 1);
  endtask

  task automatic t_ext_rising;
    wr_mode(6'b10_1000);  // pin, rising, prescaler on watchdog
    wr_cnt(8'h10);
    cyc(3);
    chk("R4 clock ignored in pin mode", cnt_o, 8'h10);
    pin_i = 1'b1; cyc(2);
    chk("R5 sync latency", cnt_o, 8'h10);
    cyc(1);
    chk("R5 rising counted", cnt_o, 8'h11);
    pin_i = 1'b0; cyc(4);
    chk("R5 falling ignored", cnt_o, 8'h11);
  endtask

  task automatic t_internal_direct;
    wr_mode(6'b00_1000);
    wr_cnt(8'h40);
    cyc(5);
    chk("R2 R4 internal every cycle", cnt_o, 8'h45);
  endtask

  task automatic t_timer_ratio(input logic [2:0] rate);
    int n = 2 << rate;
    wr_mode({3'b000, rate});
    wr_cnt(8'h20);
    cyc(n - 1);
    chk("R3 before ratio", cnt_o, 8'h20);
    cyc(1);
    chk("R3 first step", cnt_o, 8'h21);
    cyc(n);
    chk("R3 second step", cnt_o, 8'h22);
  endtask

  task automatic t_write_restarts_pre;
    wr_mode(6'b00_0010);  // ratio 8
    wr_cnt(8'h30);
    cyc(5);
    wr_cnt(8'h50);
    cyc(7);
    chk("R7 prescaler restarted", cnt_o, 8'h50);
    cyc(1);
    chk("R7 step after full ratio", cnt_o, 8'h51);
  endtask

  task automatic t_wdtclr_keeps_timer_pre;
    wr_mode(6'b00_0000);  // ratio 2 on counter
    wr_cnt(8'h60);
    cyc(1);
    wdt_clr_i = 1'b1; cyc(1); wdt_clr_i = 1'b0;
    chk("R8 counter prescaler untouched", cnt_o, 8'h61);
  endtask

  task automatic t_overflow;
    wr_mode(6'b00_1000);
    wr_cnt(8'hFE);
    cyc(1);
    chk("R6 no flag at FF", ovf_flag_o, 0);
    cyc(1);
    chk("R6 wrap value", cnt_o, 0);
    chk("R6 flag set", ovf_flag_o, 1);
    cyc(3);
    chk("R6 flag sticky", ovf_flag_o, 1);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R6 flag cleared", ovf_flag_o, 0);
    wr_cnt(8'hFF);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R6 set wins over clear", ovf_flag_o, 1);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
  endtask

  task automatic t_wdt(input logic to_wdt, input logic [2:0] rate);
    int m = to_wdt ? (256 << rate) : 256;
    wr_mode({2'b00, to_wdt, rate});
    wdt_clr_i = 1'b1; cyc(1); wdt_clr_i = 1'b0;
    wdt_tick_i = 1'b1; cyc(m - 1);
    chk("R9 no early timeout", wdt_timeout_o, 0);
    cyc(1);
    chk("R9 timeout", wdt_timeout_o, 1);
    wdt_tick_i = 1'b0; cyc(1);
    chk("R9 one-cycle pulse", wdt_timeout_o, 0);
  endtask

  task automatic t_wdtclr_restarts_pre;
    wr_mode(6'b00_1001);  // watchdog ratio 2
    wdt_clr_i = 1'b1; cyc(1); wdt_clr_i = 1'b0;
    wdt_tick_i = 1'b1; cyc(1); wdt_tick_i = 1'b0;
    wdt_clr_i = 1'b1; cyc(1); wdt_clr_i = 1'b0;
    wdt_tick_i = 1'b1; cyc(511);
    chk("R8 watchdog prescaler restarted", wdt_timeout_o, 0);
    cyc(1);
    chk("R8 timeout after full count", wdt_timeout_o, 1);
    wdt_tick_i = 1'b0; cyc(1);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rst_ni = 1'b1;
        cyc(1);
        t_reset();
        t_ext_rising();
        t_internal_direct();
        t_timer_ratio(3'd0);
        t_timer_ratio(3'd2);
        t_timer_ratio(3'd7);
        t_write_restarts_pre();
        t_wdtclr_keeps_timer_pre();
        t_overflow();
        t_wdt(1'b1, 3'd0);
        t_wdt(1'b1, 3'd1);
        t_wdt(1'b0, 3'd3);
        t_wdtclr_restarts_pre();
      end
      begin
        repeat (100000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule